// File: doc/BRIEF.md
# Register-Direct Unary and Multiply Execution Unit

This unit carries out one class of integer instructions on a register operand: bitwise complement, two's-complement negate and an unsigned widening multiply. All three sit under one opcode and are told apart by the middle three bits of the ModR/M byte. It also runs the increment and decrement forms. In the short forms the opcode's low three bits name the register. In the group form a ModR/M sub-operation field picks between increment and decrement. Only the register-direct addressing mode (ModR/M bits 7:6 equal to 3) is accepted. Any other mode, opcode or sub-operation is reported as an error.

The unit sits beside a register file it does not own. It drives a read index and receives the selected register and the accumulator (register 0) combinationally. Results go back through a single write port. The multiply is computed over several cycles in a shift-and-add engine that retires `MUL_STEP_W` multiplier bits per cycle. The 64-bit product is then written as two back-to-back register writes: the low half to register 0, the high half to register 2. A one-cycle `done` pulse follows the final write. While `busy` is high, new requests are not taken.

Top module: `unop_exec_unit`

## Requirements
- R1: Opcode 0xF7 with reg field 2 writes the bitwise inverse of the r/m register (ModR/M bits 2:0) back to it. It sets SF to result bit 31 and ZF when the result is zero, and clears OF.
- R2: Opcode 0xF7 with reg field 3, for any operand other than 0x80000000, writes the two's complement, sets SF from bit 31 and ZF for a zero result, and clears OF.
- R3: Negating 0x80000000 performs no register write, leaving the value unchanged, and sets SF=1, ZF=0, OF=1.
- R4: Opcode 0xF7 with reg field 4 forms the unsigned 64-bit product of register 0 and the r/m register. The low half goes to register 0 and the high half to register 2. OF is set exactly when the high half is nonzero, and SF and ZF keep their values.
- R5: Opcodes 0x40-0x47 increment, and 0x48-0x4F decrement, the register given by opcode bits 2:0, wrapping modulo 2^32. The flags are unchanged.
- R6: Opcode 0xFF with reg field 0 increments the r/m register, and with reg field 1 decrements it, wrapping modulo 2^32. The flags are unchanged.
- R7: An unsupported request raises `err` together with `done`, writes no register and leaves all flags unchanged. This covers 0xF7 reg fields 0, 1, 5, 6 and 7, 0xFF reg fields 2 to 7, any 0xF7/0xFF with ModR/M bits 7:6 other than 3, and any other opcode.
- R8: A request is taken on a clock edge where `op_valid` is high and `busy` is low. For every non-multiply request, `done` is high during the second cycle after the accepting edge. `op_valid` is ignored while `busy` is high.
- R9: A multiply writes register 0 and then register 2 on consecutive cycles. `done` follows one cycle later, 4 + DATA_W/MUL_STEP_W cycles after the accepting edge (8 with the defaults).
- R10: After reset, `busy`, `done`, `err`, `rf_we` and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 8 | Primary opcode byte |
| op_modrm | input | 8 | ModR/M byte (ignored for 0x40-0x4F) |
| busy | output | 1 | A request is in progress |
| rf_rd_idx | output | 3 | Index of the operand register to read |
| rf_rd_data | input | DATA_W | Contents of register `rf_rd_idx` |
| rf_acc_data | input | DATA_W | Contents of register 0 |
| rf_we | output | 1 | Register write strobe |
| rf_wr_idx | output | 3 | Register write index |
| rf_wr_data | output | DATA_W | Register write data |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported request, valid with `done` |

## Verification
Single-cycle operations put their write strobe out one cycle after acceptance and `done` one cycle later. A multiply needs its shift-and-add steps first, so `done` comes 4 + DATA_W/MUL_STEP_W edges after acceptance. The bench counts falling edges from the accepting edge until `done` and compares that count with the expected latency for each request. It compares registers and flags only at that point, when every write has reached the bench-side register file. During some multiplies it holds a conflicting request on `op_valid` for exactly the cycles that `busy` is high. This shows that such requests leave no trace.

// File: rtl/unop_pkg.sv
`timescale 1ns/1ps
package unop_pkg;

    localparam int REG_W = 3;

    localparam logic [REG_W-1:0] ACC_REG = 3'd0;
    localparam logic [REG_W-1:0] HI_REG  = 3'd2;

    localparam logic [7:0] OPC_GRP_UNARY = 8'hF7;
    localparam logic [7:0] OPC_GRP_STEP  = 8'hFF;
    localparam logic [3:0] OPC_ROW_STEP  = 4'h4;

    localparam logic [2:0] SUB_NOT = 3'd2;
    localparam logic [2:0] SUB_NEG = 3'd3;
    localparam logic [2:0] SUB_MUL = 3'd4;
    localparam logic [2:0] SUB_INC = 3'd0;
    localparam logic [2:0] SUB_DEC = 3'd1;

    typedef enum logic [2:0] {
        K_NOT,
        K_NEG,
        K_MUL,
        K_INC,
        K_DEC,
        K_BAD
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EXEC,
        S_MUL,
        S_WHI,
        S_FIN
    } state_e;

    typedef struct packed {
        kind_e            kind;
        logic [REG_W-1:0] target;
    } dec_t;

endpackage

// File: rtl/unop_decode.sv
`timescale 1ns/1ps
module unop_decode
    import unop_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output dec_t       dec
);

    logic       reg_direct;
    logic [2:0] sub_sel;

    assign reg_direct = (modrm[7:6] == 2'b11);
    assign sub_sel    = modrm[5:3];

    always_comb begin
        dec.kind   = K_BAD;
        dec.target = modrm[2:0];
        if (opcode[7:4] == OPC_ROW_STEP) begin
            dec.kind   = opcode[3] ? K_DEC : K_INC;
            dec.target = opcode[2:0];
        end else if (reg_direct && opcode == OPC_GRP_UNARY) begin
            case (sub_sel)
                SUB_NOT: dec.kind = K_NOT;
                SUB_NEG: dec.kind = K_NEG;
                SUB_MUL: dec.kind = K_MUL;
                default: dec.kind = K_BAD;
            endcase
        end else if (reg_direct && opcode == OPC_GRP_STEP) begin
            case (sub_sel)
                SUB_INC: dec.kind = K_INC;
                SUB_DEC: dec.kind = K_DEC;
                default: dec.kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/unop_alu.sv
`timescale 1ns/1ps
module unop_alu
    import unop_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  kind_e             kind,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flags_en,
    output logic              sf,
    output logic              zf,
    output logic              of
);

    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        result   = operand;
        wr_en    = 1'b0;
        flags_en = 1'b0;
        of       = 1'b0;
        case (kind)
            K_NOT: begin
                result   = ~operand;
                wr_en    = 1'b1;
                flags_en = 1'b1;
            end
            K_NEG: begin
                flags_en = 1'b1;
                if (operand == MIN_NEG) begin
                    of = 1'b1;
                end else begin
                    result = ~operand + ONE;
                    wr_en  = 1'b1;
                end
            end
            K_INC: begin
                result = operand + ONE;
                wr_en  = 1'b1;
            end
            K_DEC: begin
                result = operand - ONE;
                wr_en  = 1'b1;
            end
            default: begin
                result = operand;
            end
        endcase
        sf = result[DATA_W-1];
        zf = (result == '0) && !of;
    end

endmodule

// File: rtl/unop_mul_seq.sv
`timescale 1ns/1ps
module unop_mul_seq #(
    parameter int DATA_W     = 32,
    parameter int MUL_STEP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DATA_W-1:0]     mcand_in,
    input  logic [DATA_W-1:0]     mplier_in,
    output logic                  valid,
    output logic [2*DATA_W-1:0]   product
);

    localparam int STEPS = DATA_W / MUL_STEP_W;
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        logic [2*DATA_W-1:0] mcand;
        logic [DATA_W-1:0]   mplier;
        logic [2*DATA_W-1:0] acc;
        logic [CW-1:0]       cnt;
        logic                run;
        logic                valid;
    } mul_t;

    mul_t mul_d, mul_q;
    logic [2*DATA_W-1:0] partial;

    assign partial = mul_q.mcand *
                     {{(2*DATA_W-MUL_STEP_W){1'b0}}, mul_q.mplier[MUL_STEP_W-1:0]};

    always_comb begin
        mul_d       = mul_q;
        mul_d.valid = 1'b0;
        if (start) begin
            mul_d.mcand  = {{DATA_W{1'b0}}, mcand_in};
            mul_d.mplier = mplier_in;
            mul_d.acc    = '0;
            mul_d.cnt    = '0;
            mul_d.run    = 1'b1;
        end else if (mul_q.run) begin
            mul_d.acc    = mul_q.acc + partial;
            mul_d.mcand  = mul_q.mcand << MUL_STEP_W;
            mul_d.mplier = mul_q.mplier >> MUL_STEP_W;
            mul_d.cnt    = mul_q.cnt + 1'b1;
            if (mul_q.cnt == LAST) begin
                mul_d.run   = 1'b0;
                mul_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mul_q <= '0;
        else        mul_q <= mul_d;
    end

    assign valid   = mul_q.valid;
    assign product = mul_q.acc;

    // R9
    mul_valid_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_q.valid |-> $past(mul_q.run));

    // R9
    mul_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !mul_q.run);

endmodule

// File: rtl/unop_exec_unit.sv
`timescale 1ns/1ps
module unop_exec_unit
    import unop_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int MUL_STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        op_code,
    input  logic [7:0]        op_modrm,
    output logic              busy,
    output logic [2:0]        rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    input  logic [DATA_W-1:0] rf_acc_data,
    output logic              rf_we,
    output logic [2:0]        rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              flag_sf,
    output logic              flag_zf,
    output logic              flag_of,
    output logic              done,
    output logic              err
);

    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        state_e            st;
        dec_t              dec;
        logic              we;
        logic [REG_W-1:0]  widx;
        logic [DATA_W-1:0] wdata;
        logic              sf;
        logic              zf;
        logic              of;
        logic              done;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    dec_t                dec_w;
    logic [DATA_W-1:0]   alu_res;
    logic                alu_we, alu_fe, alu_sf, alu_zf, alu_of;
    logic                mul_start, mul_valid;
    logic [2*DATA_W-1:0] mul_prod;

    unop_decode dec_i (
        .opcode (op_code),
        .modrm  (op_modrm),
        .dec    (dec_w)
    );

    unop_alu #(.DATA_W(DATA_W)) alu_i (
        .kind     (ctl_q.dec.kind),
        .operand  (rf_rd_data),
        .result   (alu_res),
        .wr_en    (alu_we),
        .flags_en (alu_fe),
        .sf       (alu_sf),
        .zf       (alu_zf),
        .of       (alu_of)
    );

    unop_mul_seq #(.DATA_W(DATA_W), .MUL_STEP_W(MUL_STEP_W)) mul_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mul_start),
        .mcand_in  (rf_acc_data),
        .mplier_in (rf_rd_data),
        .valid     (mul_valid),
        .product   (mul_prod)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.we   = 1'b0;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        mul_start  = 1'b0;
        case (ctl_q.st)
            S_IDLE: begin
                if (op_valid) begin
                    ctl_d.dec = dec_w;
                    ctl_d.st  = S_EXEC;
                end
            end
            S_EXEC: begin
                if (ctl_q.dec.kind == K_MUL) begin
                    mul_start = 1'b1;
                    ctl_d.st  = S_MUL;
                end else begin
                    ctl_d.we    = alu_we;
                    ctl_d.widx  = ctl_q.dec.target;
                    ctl_d.wdata = alu_res;
                    if (alu_fe) begin
                        ctl_d.sf = alu_sf;
                        ctl_d.zf = alu_zf;
                        ctl_d.of = alu_of;
                    end
                    ctl_d.st = S_FIN;
                end
            end
            S_MUL: begin
                if (mul_valid) begin
                    ctl_d.we    = 1'b1;
                    ctl_d.widx  = ACC_REG;
                    ctl_d.wdata = mul_prod[DATA_W-1:0];
                    ctl_d.st    = S_WHI;
                end
            end
            S_WHI: begin
                ctl_d.we    = 1'b1;
                ctl_d.widx  = HI_REG;
                ctl_d.wdata = mul_prod[2*DATA_W-1:DATA_W];
                ctl_d.of    = |mul_prod[2*DATA_W-1:DATA_W];
                ctl_d.st    = S_FIN;
            end
            S_FIN: begin
                ctl_d.done = 1'b1;
                ctl_d.err  = (ctl_q.dec.kind == K_BAD);
                ctl_d.st   = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy       = (ctl_q.st != S_IDLE);
    assign rf_rd_idx  = ctl_q.dec.target;
    assign rf_we      = ctl_q.we;
    assign rf_wr_idx  = ctl_q.widx;
    assign rf_wr_data = ctl_q.wdata;
    assign flag_sf    = ctl_q.sf;
    assign flag_zf    = ctl_q.zf;
    assign flag_of    = ctl_q.of;
    assign done       = ctl_q.done;
    assign err        = ctl_q.err;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> busy);

    // R7
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R7
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(rf_we));

    // R9
    mul_pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(rf_we)) |-> (rf_wr_idx == HI_REG && $past(rf_wr_idx) == ACC_REG));

    // R3
    neg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_FIN && ctl_q.dec.kind == K_NEG && $past(rf_rd_data) == MIN_NEG)
        |-> (!rf_we && flag_sf && !flag_zf && flag_of));

    // R5
    step_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_FIN && (ctl_q.dec.kind == K_INC || ctl_q.dec.kind == K_DEC))
        |-> $stable({flag_sf, flag_zf, flag_of}));

endmodule

// File: tb/unop_exec_unit_tb.sv
`timescale 1ns/1ps
module unop_exec_unit_tb_top;

    localparam int DW      = 32;
    localparam int STEP_W  = 8;
    localparam int MUL_LAT = 4 + DW / STEP_W;
    localparam int ONE_LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_valid;
    logic [7:0]    op_code;
    logic [7:0]    op_modrm;
    logic          busy;
    logic [2:0]    rf_rd_idx;
    logic [DW-1:0] rf_rd_data;
    logic [DW-1:0] rf_acc_data;
    logic          rf_we;
    logic [2:0]    rf_wr_idx;
    logic [DW-1:0] rf_wr_data;
    logic          flag_sf, flag_zf, flag_of;
    logic          done, err;

    logic [DW-1:0] rf  [8];
    logic [DW-1:0] mdl [8];
    logic          m_sf, m_zf, m_of;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    unop_exec_unit #(.DATA_W(DW), .MUL_STEP_W(STEP_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .op_modrm    (op_modrm),
        .busy        (busy),
        .rf_rd_idx   (rf_rd_idx),
        .rf_rd_data  (rf_rd_data),
        .rf_acc_data (rf_acc_data),
        .rf_we       (rf_we),
        .rf_wr_idx   (rf_wr_idx),
        .rf_wr_data  (rf_wr_data),
        .flag_sf     (flag_sf),
        .flag_zf     (flag_zf),
        .flag_of     (flag_of),
        .done        (done),
        .err         (err)
    );

    assign rf_rd_data  = rf[rf_rd_idx];
    assign rf_acc_data = rf[0];

    always @(posedge clk) begin
        if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_reg(input int idx, input logic [DW-1:0] v);
        rf[idx]  = v;
        mdl[idx] = v;
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [7:0] mrm,
                          input string req, input bit inject);
        bit            exp_err;
        int            exp_lat, lat, tgt;
        logic [DW-1:0] v;
        logic [63:0]   p;
        bit            rd;
        exp_err = 1'b0;
        exp_lat = ONE_LAT;
        rd  = (mrm[7:6] == 2'b11);
        tgt = int'(mrm[2:0]);
        v   = mdl[tgt];
        if (opc[7:4] == 4'h4) begin
            tgt = int'(opc[2:0]);
            if (opc[3]) mdl[tgt] = mdl[tgt] - 1;
            else        mdl[tgt] = mdl[tgt] + 1;
        end else if (rd && opc == 8'hF7) begin
            case (mrm[5:3])
                3'd2: begin
                    mdl[tgt] = ~v;
                    m_sf = mdl[tgt][DW-1]; m_zf = (mdl[tgt] == 0); m_of = 1'b0;
                end
                3'd3: begin
                    if (v == 32'h8000_0000) begin
                        m_sf = 1'b1; m_zf = 1'b0; m_of = 1'b1;
                    end else begin
                        mdl[tgt] = 32'd0 - v;
                        m_sf = mdl[tgt][DW-1]; m_zf = (mdl[tgt] == 0); m_of = 1'b0;
                    end
                end
                3'd4: begin
                    p = {32'd0, mdl[0]} * {32'd0, v};
                    mdl[0] = p[31:0];
                    mdl[2] = p[63:32];
                    m_of = (p[63:32] != 0);
                    exp_lat = MUL_LAT;
                end
                default: exp_err = 1'b1;
            endcase
        end else if (rd && opc == 8'hFF) begin
            case (mrm[5:3])
                3'd0: mdl[tgt] = v + 1;
                3'd1: mdl[tgt] = v - 1;
                default: exp_err = 1'b1;
            endcase
        end else begin
            exp_err = 1'b1;
        end

        op_valid = 1'b1;
        op_code  = opc;
        op_modrm = mrm;
        @(negedge clk);
        op_valid = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            if (inject) begin
                op_valid = busy;
                op_code  = 8'h40;
            end
            @(negedge clk);
            lat++;
        end
        op_valid = 1'b0;

        chk(lat == exp_lat, (exp_lat == ONE_LAT) ? "R8" : "R9", "latency",
            64'(lat), 64'(exp_lat));
        chk(err == exp_err, req, "err", 64'(err), 64'(exp_err));
        for (int i = 0; i < 8; i++) begin
            chk(rf[i] == mdl[i], req, $sformatf("reg%0d op %h/%h", i, opc, mrm),
                64'(rf[i]), 64'(mdl[i]));
        end
        chk({flag_sf, flag_zf, flag_of} == {m_sf, m_zf, m_of}, req, "flags sf/zf/of",
            64'({flag_sf, flag_zf, flag_of}), 64'({m_sf, m_zf, m_of}));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] pats [6];
        logic [DW-1:0] mvals [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0F0F_00FF;
        pats[3] = 32'h7FFF_FFFF; pats[4] = 32'h0000_0001; pats[5] = 32'hFFFF_FFFD;
        mvals[0] = 32'h0000_0000; mvals[1] = 32'h0000_0001; mvals[2] = 32'hFFFF_FFFF;
        mvals[3] = 32'h1234_5678; mvals[4] = 32'h8000_0000; mvals[5] = 32'h0001_0000;
        for (int i = 0; i < 8; i++) set_reg(i, 32'h1000_0000 + i);
        m_sf = 1'b0; m_zf = 1'b0; m_of = 1'b0;
        op_valid = 1'b0; op_code = 8'h00; op_modrm = 8'h00;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(!busy && !done && !err && !rf_we, "R10", "control", 
            64'({busy, done, err, rf_we}), 64'h0);
        chk({flag_sf, flag_zf, flag_of} == 3'b000, "R10", "flags",
            64'({flag_sf, flag_zf, flag_of}), 64'h0);

        // R4 check case: 4 * 3 via ECX
        set_reg(0, 32'd4); set_reg(1, 32'd3);
        run_op(8'hF7, 8'hE1, "R4", 1'b0);
        chk(rf[0] == 32'h0000_000C, "R4", "fixed product", 64'(rf[0]), 64'hC);

        // R1 complement, every register and pattern
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 6; k++) begin
                set_reg(r, pats[k]);
                run_op(8'hF7, {2'b11, 3'd2, 3'(r)}, "R1", 1'b0);
            end
        end

        // R2 negate, R3 most negative value
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 6; k++) begin
                set_reg(r, pats[k]);
                run_op(8'hF7, {2'b11, 3'd3, 3'(r)}, "R2", 1'b0);
            end
            set_reg(r, 32'h8000_0000);
            run_op(8'hF7, {2'b11, 3'd3, 3'(r)}, "R3", 1'b0);
        end

        // R4 multiply sweep, R8 requests held while busy
        for (int r = 0; r < 8; r++) begin
            for (int a = 0; a < 6; a++) begin
                for (int b = 0; b < 6; b++) begin
                    set_reg(r, mvals[b]);
                    set_reg(0, (r == 0) ? mvals[b] : mvals[a]);
                    run_op(8'hF7, {2'b11, 3'd4, 3'(r)}, "R4", (b == 3));
                end
            end
        end

        // R5 short increment / decrement forms, with wrap
        for (int o = 8'h40; o <= 8'h4F; o++) begin
            for (int k = 0; k < 3; k++) begin
                set_reg(o & 7, pats[k + 1 - (k == 2 ? 3 : 0)]);
                run_op(8'(o), 8'h00, "R5", 1'b0);
            end
        end

        // R6 group increment / decrement
        for (int m = 8'hC0; m <= 8'hCF; m++) begin
            for (int k = 0; k < 2; k++) begin
                set_reg(m & 7, pats[k]);
                run_op(8'hFF, 8'(m), "R6", 1'b0);
            end
        end

        // R7 unsupported requests, flags preset nonzero first
        set_reg(5, 32'h8000_0000);
        run_op(8'hF7, 8'hDD, "R3", 1'b0);
        foreach (mvals[k]) begin
            set_reg(k, 32'hA5A5_0000 + k);
        end
        for (int s = 0; s < 8; s++) begin
            if (s < 2 || s > 4) run_op(8'hF7, {2'b11, 3'(s), 3'd1}, "R7", 1'b0);
            if (s > 1)          run_op(8'hFF, {2'b11, 3'(s), 3'd1}, "R7", 1'b0);
        end
        for (int md = 0; md < 3; md++) begin
            run_op(8'hF7, {2'(md), 3'd2, 3'd3}, "R7", 1'b0);
            run_op(8'hFF, {2'(md), 3'd0, 3'd3}, "R7", 1'b0);
        end
        run_op(8'h90, 8'hC0, "R7", 1'b0);
        run_op(8'h01, 8'hD8, "R7", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule